// File: doc/BRIEF.md
# Condition-Code Setting ALU

This block is the execute-stage arithmetic and logic unit of a small pipelined core with 32-bit registers. A 5-bit operation code selects one of fourteen operations on two 32-bit operands and a 16-bit immediate. The operations are complement, negate, increment, decrement, compare, add, subtract, AND, OR, XOR, add-immediate, single-bit set, and rotate left or right through carry. The block also receives the current 4-bit condition code. It returns the result, the next condition code and a per-flag write enable, so the pipeline can forward or commit the flags independently of the data.

The block is purely combinational. Zero and negative follow one update rule and carry follows another, and both rules depend on the class of the operation. The two rotates treat carry as a 33rd bit of the rotated word. An operation code that is not an ALU operation passes the first operand straight through, writes no flag and raises no result-write indication.

Top module: `cc_alu`

## Requirements
- R1: NOT (10000) yields ~opA. AND (00110), OR (00111) and XOR (01000) yield opA combined bitwise with opB.
- R2: ADD (00011) yields opA+opB. ADDI (00100) yields opA plus the sign-extended 16-bit immediate. INC (10010) yields opA+1. For each of these, carry is the carry-out of the 32-bit sum.
- R3: SUB (00101) yields opA-opB, DEC (10011) yields opA-1 and NEG (10001) yields 0-opA. Each is computed as x+~y+1, and carry is the carry-out of that sum.
- R4: Flag bit 0 (zero) and bit 1 (negative) are written by every operation in R1, R2, R3, R7 and R8, and by rotates with a non-zero amount. When written, zero equals (result==0) and negative equals result bit 31.
- R5: Flag bit 2 (carry) is written only by the operations of R2, R3 and R7 and by rotates with a non-zero amount. NOT, AND, OR, XOR and BITSET do not write it and pass flagsIn bit 2 through.
- R6: Every flagsOut bit whose flagWe bit is 0 equals the matching flagsIn bit. Bit 3 is never written.
- R7: CMP (10101) sets the flags as SUB of the same operands would, and holds resultWrite at 0.
- R8: BITSET (10110) yields opA with bit imm[4:0] set.
- R9: RCL (10111) rotates the 33-bit word {carry, opA} left by imm[4:0]. The result is the low 32 bits and carry becomes the top bit.
- R10: RCR (11000) rotates {carry, opA} right by imm[4:0], with the same split as R9.
- R11: A rotate with imm[4:0]=0 yields opA and writes no flag.
- R12: Any other opcode yields opA, with flagWe=0 and resultWrite=0. Every operation in R1 to R3 and R8 to R10 raises resultWrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 5 | Operation code |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| imm | input | 16 | Immediate value |
| flagsIn | input | 4 | Current condition code (bit0 zero, bit1 negative, bit2 carry) |
| result | output | 32 | Operation result |
| flagsOut | output | 4 | Next condition code |
| flagWe | output | 4 | Per-flag write enable |
| resultWrite | output | 1 | Result is meant for the destination register |

## Verification
The embedded checks test, on every evaluation, relations that hold for every opcode. Zero and negative must agree with the result whenever they are written. Unwritten flags and the reserved bit must pass through. Carry must stay unwritten for logical operations. Non-ALU codes must pass opA with no side effects, and compare must never request a result write. The actual arithmetic values can only be shown by the bench scenarios against its own model. These values are the sums and carries, the rotate bit order, the carry of a negated zero, the signed overflow of 0x7FFFFFFF+1 and the zero-amount rotate.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  localparam int FLAG_Z = 0;
  localparam int FLAG_N = 1;
  localparam int FLAG_C = 2;
  localparam int FLAG_W = 4;

  localparam logic [4:0] OP_NOT    = 5'b10000;
  localparam logic [4:0] OP_NEG    = 5'b10001;
  localparam logic [4:0] OP_INC    = 5'b10010;
  localparam logic [4:0] OP_DEC    = 5'b10011;
  localparam logic [4:0] OP_CMP    = 5'b10101;
  localparam logic [4:0] OP_ADD    = 5'b00011;
  localparam logic [4:0] OP_SUB    = 5'b00101;
  localparam logic [4:0] OP_AND    = 5'b00110;
  localparam logic [4:0] OP_OR     = 5'b00111;
  localparam logic [4:0] OP_XOR    = 5'b01000;
  localparam logic [4:0] OP_ADDI   = 5'b00100;
  localparam logic [4:0] OP_BITSET = 5'b10110;
  localparam logic [4:0] OP_RCL    = 5'b10111;
  localparam logic [4:0] OP_RCR    = 5'b11000;

  typedef enum logic [3:0] {
    K_PASS, K_NOT, K_AND, K_OR, K_XOR, K_ARITH, K_BSET, K_RCL, K_RCR
  } aluKind_t;

  typedef enum logic [1:0] {
    RS_B, RS_IMM, RS_ONE, RS_A
  } rightSel_t;

  typedef struct packed {
    aluKind_t  kind;
    logic      leftZero;
    rightSel_t rightSel;
    logic      invertRight;
    logic      updZn;
    logic      updC;
    logic      writeRes;
  } aluStrobes_t;
endpackage

// File: rtl/cc_alu_ctrl.sv
module cc_alu_ctrl
  import cc_alu_pkg::*;
#(
  parameter int AMT_W = 5
) (
  input  logic [4:0]       opcode,
  input  logic [AMT_W-1:0] rotAmt,
  output aluStrobes_t      strobes
);
  logic rotLive;
  assign rotLive = (rotAmt != '0);

  always_comb begin
    strobes = '{kind: K_PASS, leftZero: 1'b0, rightSel: RS_B,
                invertRight: 1'b0, updZn: 1'b0, updC: 1'b0, writeRes: 1'b0};
    unique case (opcode)
      OP_NOT:    begin strobes.kind = K_NOT; strobes.updZn = 1'b1; strobes.writeRes = 1'b1; end
      OP_AND:    begin strobes.kind = K_AND; strobes.updZn = 1'b1; strobes.writeRes = 1'b1; end
      OP_OR:     begin strobes.kind = K_OR;  strobes.updZn = 1'b1; strobes.writeRes = 1'b1; end
      OP_XOR:    begin strobes.kind = K_XOR; strobes.updZn = 1'b1; strobes.writeRes = 1'b1; end
      OP_BITSET: begin strobes.kind = K_BSET; strobes.updZn = 1'b1; strobes.writeRes = 1'b1; end
      OP_ADD, OP_ADDI, OP_INC, OP_SUB, OP_CMP, OP_DEC, OP_NEG: begin
        strobes.kind        = K_ARITH;
        strobes.updZn       = 1'b1;
        strobes.updC        = 1'b1;
        strobes.writeRes    = (opcode != OP_CMP);
        strobes.leftZero    = (opcode == OP_NEG);
        strobes.invertRight = (opcode == OP_SUB) || (opcode == OP_CMP) ||
                              (opcode == OP_DEC) || (opcode == OP_NEG);
        strobes.rightSel    = (opcode == OP_ADDI) ? RS_IMM :
                              ((opcode == OP_INC) || (opcode == OP_DEC)) ? RS_ONE :
                              (opcode == OP_NEG) ? RS_A : RS_B;
      end
      OP_RCL, OP_RCR: begin
        strobes.kind     = (opcode == OP_RCL) ? K_RCL : K_RCR;
        strobes.updZn    = rotLive;
        strobes.updC     = rotLive;
        strobes.writeRes = 1'b1;
      end
      default: ;
    endcase
  end

  // R7: compare never requests a destination write
  always_comb begin
    if (opcode == OP_CMP)
      assert_cmp_no_write_R7: assert (!strobes.writeRes && strobes.updC)
        else $error("CMP strobes wrong");
  end
endmodule

// File: rtl/cc_alu_path.sv
module cc_alu_path
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  aluStrobes_t       strobes,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [WIDTH-1:0]  result,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [FLAG_W-1:0] flagWe
);
  localparam int ROT_W = WIDTH + 1;

  logic [WIDTH-1:0]   immExt, leftVal, rightRaw, rightVal;
  logic [WIDTH:0]     sumFull;
  logic [ROT_W-1:0]   rotWord, rotOut;
  logic [2*ROT_W-1:0] rotPair, rotLeftPair, rotRightPair;
  logic [AMT_W-1:0]   amt;
  logic               newCarry;
  logic [FLAG_W-1:0]  newFlags;

  assign immExt   = {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm};
  assign amt      = imm[AMT_W-1:0];
  assign leftVal  = strobes.leftZero ? '0 : opA;

  always_comb begin
    unique case (strobes.rightSel)
      RS_IMM:  rightRaw = immExt;
      RS_ONE:  rightRaw = WIDTH'(1);
      RS_A:    rightRaw = opA;
      default: rightRaw = opB;
    endcase
  end

  assign rightVal = strobes.invertRight ? ~rightRaw : rightRaw;
  assign sumFull  = {1'b0, leftVal} + {1'b0, rightVal} + {{WIDTH{1'b0}}, strobes.invertRight};

  assign rotWord      = {flagsIn[FLAG_C], opA};
  assign rotPair      = {rotWord, rotWord};
  assign rotLeftPair  = rotPair << amt;
  assign rotRightPair = rotPair >> amt;
  assign rotOut       = (strobes.kind == K_RCL) ? rotLeftPair[2*ROT_W-1:ROT_W]
                                                : rotRightPair[ROT_W-1:0];

  always_comb begin
    newCarry = flagsIn[FLAG_C];
    unique case (strobes.kind)
      K_NOT:   result = ~opA;
      K_AND:   result = opA & opB;
      K_OR:    result = opA | opB;
      K_XOR:   result = opA ^ opB;
      K_BSET:  result = opA | (WIDTH'(1) << amt);
      K_ARITH: begin result = sumFull[WIDTH-1:0]; newCarry = sumFull[WIDTH]; end
      K_RCL, K_RCR: begin result = rotOut[WIDTH-1:0]; newCarry = rotOut[WIDTH]; end
      default: result = opA;
    endcase
  end

  always_comb begin
    newFlags          = flagsIn;
    newFlags[FLAG_Z]  = (result == '0);
    newFlags[FLAG_N]  = result[WIDTH-1];
    newFlags[FLAG_C]  = newCarry;
    flagWe            = '0;
    flagWe[FLAG_Z]    = strobes.updZn;
    flagWe[FLAG_N]    = strobes.updZn;
    flagWe[FLAG_C]    = strobes.updC;
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_merge
    assign flagsOut[i] = flagWe[i] ? newFlags[i] : flagsIn[i];
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [4:0]        opcode,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [WIDTH-1:0]  result,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [FLAG_W-1:0] flagWe,
  output logic              resultWrite
);
  localparam int AMT_W = $clog2(WIDTH);

  aluStrobes_t strobes;

  cc_alu_ctrl #(.AMT_W(AMT_W)) uCtrl (
    .opcode (opcode),
    .rotAmt (imm[AMT_W-1:0]),
    .strobes(strobes)
  );

  cc_alu_path #(.WIDTH(WIDTH), .IMM_W(IMM_W), .AMT_W(AMT_W)) uPath (
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .imm     (imm),
    .flagsIn (flagsIn),
    .result  (result),
    .flagsOut(flagsOut),
    .flagWe  (flagWe)
  );

  assign resultWrite = strobes.writeRes;

  always_comb begin
    // R4: written zero/negative agree with the result
    if (flagWe[FLAG_Z])
      assert_zero_tracks_R4: assert (flagsOut[FLAG_Z] == (result == '0)) else $error("zero flag");
    if (flagWe[FLAG_N])
      assert_neg_tracks_R4: assert (flagsOut[FLAG_N] == result[WIDTH-1]) else $error("neg flag");
    // R5: logical operations leave carry alone
    if (opcode == OP_NOT || opcode == OP_AND || opcode == OP_OR ||
        opcode == OP_XOR || opcode == OP_BITSET)
      assert_carry_kept_R5: assert (!flagWe[FLAG_C] && flagsOut[FLAG_C] == flagsIn[FLAG_C])
        else $error("carry touched");
    // R6: reserved bit never written and passes through
    assert_reserved_R6: assert (!flagWe[3] && flagsOut[3] == flagsIn[3]) else $error("bit3");
    // R12: unknown codes are transparent
    if (strobes.kind == K_PASS)
      assert_pass_R12: assert (result == opA && flagWe == '0 && !resultWrite) else $error("pass");
  end
endmodule

// File: tb/sim_cc_alu.sv
module sim_cc_alu;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  opcode;
  logic [31:0] opA, opB, result;
  logic [15:0] imm;
  logic [3:0]  flagsIn, flagsOut, flagWe;
  logic        resultWrite;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  cc_alu u0 (.opcode(opcode), .opA(opA), .opB(opB), .imm(imm), .flagsIn(flagsIn),
             .result(result), .flagsOut(flagsOut), .flagWe(flagWe), .resultWrite(resultWrite));

  function automatic string reqFor(input logic [4:0] op, input logic [15:0] im);
    case (op)
      5'b10000, 5'b00110, 5'b00111, 5'b01000: return "R1";
      5'b00011, 5'b00100, 5'b10010: return "R2";
      5'b00101, 5'b10011, 5'b10001: return "R3";
      5'b10101: return "R7";
      5'b10110: return "R8";
      5'b10111: return (im[4:0] == 0) ? "R11" : "R9";
      5'b11000: return (im[4:0] == 0) ? "R11" : "R10";
      default:  return "R12";
    endcase
  endfunction

  task automatic refModel(input logic [4:0] op, input logic [31:0] a, b, input logic [15:0] im,
                          input logic [3:0] fi, output logic [31:0] r, output logic [3:0] fo,
                          output logic [3:0] we, output logic w);
    logic [32:0] s;
    logic zn, cw, c, cc;
    zn = 0; cw = 0; c = fi[2]; r = a; w = 0; s = '0;
    case (op)
      5'b10000: begin r = ~a; zn = 1; w = 1; end
      5'b00110: begin r = a & b; zn = 1; w = 1; end
      5'b00111: begin r = a | b; zn = 1; w = 1; end
      5'b01000: begin r = a ^ b; zn = 1; w = 1; end
      5'b10110: begin r = a; r[im[4:0]] = 1'b1; zn = 1; w = 1; end
      5'b00011: begin s = {1'b0, a} + {1'b0, b}; w = 1; end
      5'b00100: begin s = {1'b0, a} + {1'b0, {{16{im[15]}}, im}}; w = 1; end
      5'b10010: begin s = {1'b0, a} + 33'd1; w = 1; end
      5'b00101: begin s = {1'b0, a} + {1'b0, ~b} + 33'd1; w = 1; end
      5'b10101: begin s = {1'b0, a} + {1'b0, ~b} + 33'd1; end
      5'b10011: begin s = {1'b0, a} + {1'b0, ~32'd1} + 33'd1; w = 1; end
      5'b10001: begin s = {1'b0, ~a} + 33'd1; w = 1; end
      5'b10111, 5'b11000: begin
        cc = fi[2]; w = 1;
        for (int k = 0; k < int'(im[4:0]); k++) begin
          if (op == 5'b10111) begin logic t; t = r[31]; r = {r[30:0], cc}; cc = t; end
          else begin logic t; t = r[0]; r = {cc, r[31:1]}; cc = t; end
        end
        if (im[4:0] != 0) begin zn = 1; cw = 1; c = cc; end
      end
      default: ;
    endcase
    if (op inside {5'b00011, 5'b00100, 5'b10010, 5'b00101, 5'b10101, 5'b10011, 5'b10001}) begin
      r = s[31:0]; c = s[32]; zn = 1; cw = 1;
    end
    fo = fi;
    if (zn) begin fo[0] = (r == 0); fo[1] = r[31]; end
    if (cw) fo[2] = c;
    we = {1'b0, cw, zn, zn};
  endtask

  task automatic applyCheck(input logic [4:0] op, input logic [31:0] a, b,
                            input logic [15:0] im, input logic [3:0] fi, input string note);
    logic [31:0] er; logic [3:0] ef, ew; logic ewr;
    @(posedge clk);
    opcode = op; opA = a; opB = b; imm = im; flagsIn = fi;
    refModel(op, a, b, im, fi, er, ef, ew, ewr);
    @(negedge clk);
    checks++;
    if (result !== er || flagsOut !== ef || flagWe !== ew || resultWrite !== ewr) begin
      errors++;
      $display("FAIL %s %s op=%b: got r=%h f=%b we=%b w=%b, expected r=%h f=%b we=%b w=%b",
               reqFor(op, im), note, op, result, flagsOut, flagWe, resultWrite, er, ef, ew, ewr);
    end
  endtask

  initial begin
    #40000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    opcode = '0; opA = '0; opB = '0; imm = '0; flagsIn = '0;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    applyCheck(5'b00000, 32'h0, 32'h0, 16'h0, 4'b0000, "R12 idle state");
    applyCheck(5'b00011, 32'h7FFFFFFF, 32'h1, 16'h0, 4'b0101, "R2 signed overflow");
    applyCheck(5'b00011, 32'hFFFFFFFF, 32'h1, 16'h0, 4'b0000, "R2 carry out");
    applyCheck(5'b00100, 32'h5, 16'hFFFF, 16'hFFFF, 4'b0000, "R2 ADDI negative imm");
    applyCheck(5'b10001, 32'h0, 32'h0, 16'h0, 4'b0000, "R3 negate zero");
    applyCheck(5'b10011, 32'h0, 32'h0, 16'h0, 4'b0100, "R3 decrement zero");
    applyCheck(5'b10101, 32'h1234, 32'h1234, 16'h0, 4'b0000, "R7 compare equal");
    applyCheck(5'b00110, 32'hF0F0F0F0, 32'h0F0F0F0F, 16'h0, 4'b1100, "R5 R6 AND keeps carry");
    applyCheck(5'b10110, 32'h0, 32'h0, 16'h001F, 4'b0100, "R8 bit 31");
    applyCheck(5'b10111, 32'h80000001, 32'h0, 16'h0001, 4'b0000, "R9 by one");
    applyCheck(5'b11000, 32'h80000001, 32'h0, 16'h0001, 4'b0100, "R10 by one");
    applyCheck(5'b10111, 32'hDEADBEEF, 32'h0, 16'hFFE0, 4'b1111, "R11 zero amount");
    applyCheck(5'b11000, 32'hDEADBEEF, 32'h0, 16'h0000, 4'b0010, "R11 zero amount");
    applyCheck(5'b11111, 32'hCAFEF00D, 32'h1, 16'h1, 4'b1010, "R12 non-ALU");
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] im;
      logic [31:0] a;
      im = 16'($urandom);
      if (($urandom % 8) == 0) im[4:0] = 5'd0;
      a = $urandom;
      if (($urandom % 16) == 0) a = 32'h0;
      applyCheck(5'($urandom), a, $urandom, im, 4'($urandom), "random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule